// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Engine

This block runs the descriptor side of one scatter-gather DMA channel. Software fills the channel's register window with the first segment's addresses, byte count, chain pointer and control word. Writing the control register with its enable bit set launches the segment. The engine presents the segment to an external byte mover and waits for that mover's completion pulse. It then either stops or loads the next descriptor from memory and launches that one.

Descriptors are 64-byte, 32-byte-aligned records in memory. Only their first nine 32-bit words carry meaning, and they appear in the same order as the channel registers. The engine reads these nine words one at a time over a simple request/valid read port. Each word is written straight into the live register it belongs to. A zero chain pointer ends the chain. The chain-pointer register can be read at any time, so software can work out how far a chain has progressed. Per-dimension stepping is carried in registers but is not acted on here.

Top module: `desc_chain_engine`

## Requirements
- R1: Registers are addressed by word index (byte offset divided by four). Index 0 is source address, 1 destination address, 2 byte count, 3 ZY count, 4 source step, 5 destination step, 7 chain pointer, 8 control. Indices 6 and 9 to 15 ignore writes and read as zero. Read data appears on `reg_rd_data` one clock after `reg_rd_word` is presented.
- R2: Source and destination addresses keep bits [1:0] at zero, the chain pointer keeps bits [4:0] at zero, and the byte count keeps only its low 16 bits. These masks apply to both software writes and fetched words.
- R3: While idle, a control write with bit 0 set stores the control value. On the next cycle `busy` goes high and `seg_valid` is high for exactly one cycle, presenting the source, destination, byte count and control values.
- R4: While busy, every register write is ignored except a control write with bit 0 clear.
- R5: A `seg_done` pulse during an active segment whose chain pointer is zero makes `busy` low on the next cycle and clears control bit 0.
- R6: A `seg_done` pulse during an active segment whose chain pointer is non-zero makes `mem_req` high on the next cycle, with `mem_addr` equal to the pointer. A word is transferred on a cycle with both `mem_req` and `mem_rvalid` high. Each transfer advances `mem_addr` by 4, and `mem_addr` holds while `mem_rvalid` is low. Exactly nine words are read.
- R7: Fetched words 0 to 5, 7 and 8 replace source, destination, byte count, ZY count, source step, destination step, chain pointer and control. Word 6 is discarded.
- R8: The cycle after the ninth word is taken, `mem_req` is low. If the fetched control bit 0 is 1, `seg_valid` pulses with the new segment. If it is 0, `busy` goes low and no segment is issued.
- R9: The chain pointer reads back its live value during a chain. It holds the address of the descriptor being fetched until word 7 arrives, and the new pointer from then on.
- R10: While busy, a control write with bit 0 clear stores the written value. On the next cycle `busy`, `mem_req` and `seg_valid` are all low.
- R11: A `seg_done` pulse while idle or while fetching has no effect.
- R12: After reset, `busy`, `seg_valid` and `mem_req` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_word | input | 4 | Word index of register write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_word | input | 4 | Word index of register read |
| reg_rd_data | output | 32 | Registered read data, one cycle latency |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of requested word |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | One-cycle segment launch pulse |
| seg_src | output | 32 | Segment source address |
| seg_dst | output | 32 | Segment destination address |
| seg_len | output | 16 | Segment byte count |
| seg_ctrl | output | 32 | Segment control word |
| seg_done | input | 1 | Byte mover completion pulse |
| busy | output | 1 | Channel active |

## Verification
Most wrong internal state in this engine shows up at the ports within a cycle. A wrong word counter either sends an address off the +4 sequence or ends the read burst early or late, which is visible on `mem_req`/`mem_addr` the same cycle. A wrong store index puts a wrong value on `seg_src`, `seg_len` or `seg_ctrl` at the very next launch pulse. A stale or premature chain-pointer update is caught through the readable pointer register one cycle after the word arrives. A lost completion or stop decode shows as `busy` staying high past the cycle it should fall. The bench keeps a behavioural model in step with every clock, so each such divergence is reported on the cycle it first appears.

// File: rtl/ldf_pkg.sv
package ldf_pkg;
  localparam int IDX_W = 4;

  // register word indices; descriptor words use the same order
  localparam logic [IDX_W-1:0] W_SRC   = 4'd0;
  localparam logic [IDX_W-1:0] W_DST   = 4'd1;
  localparam logic [IDX_W-1:0] W_XCNT  = 4'd2;
  localparam logic [IDX_W-1:0] W_ZY    = 4'd3;
  localparam logic [IDX_W-1:0] W_SSTEP = 4'd4;
  localparam logic [IDX_W-1:0] W_DSTEP = 4'd5;
  localparam logic [IDX_W-1:0] W_LINK  = 4'd7;
  localparam logic [IDX_W-1:0] W_CTRL  = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2
  } ldf_state_e;
endpackage

// File: rtl/ldf_regs.sv
module ldf_regs
  import ldf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 16,
  parameter int WORD_LSB = 2,
  parameter int LINK_LSB = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] dst,
  output logic [LEN_W-1:0]  xcnt,
  output logic [DATA_W-1:0] link,
  output logic [DATA_W-1:0] ctrl
);
  localparam int PAD_W = DATA_W - LEN_W;

  logic [DATA_W-1:0] zy, sstep, dstep;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (ridx)
      W_SRC:   rd_mux = src;
      W_DST:   rd_mux = dst;
      W_XCNT:  rd_mux = {{PAD_W{1'b0}}, xcnt};
      W_ZY:    rd_mux = zy;
      W_SSTEP: rd_mux = sstep;
      W_DSTEP: rd_mux = dstep;
      W_LINK:  rd_mux = link;
      W_CTRL:  rd_mux = ctrl;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src   <= '0;
      dst   <= '0;
      xcnt  <= '0;
      zy    <= '0;
      sstep <= '0;
      dstep <= '0;
      link  <= '0;
      ctrl  <= '0;
      rdata <= '0;
    end else begin
      rdata <= rd_mux;
      if (we) begin
        case (widx)
          W_SRC:   src   <= {wdata[DATA_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
          W_DST:   dst   <= {wdata[DATA_W-1:WORD_LSB], {WORD_LSB{1'b0}}};
          W_XCNT:  xcnt  <= wdata[LEN_W-1:0];
          W_ZY:    zy    <= wdata;
          W_SSTEP: sstep <= wdata;
          W_DSTEP: dstep <= wdata;
          W_LINK:  link  <= {wdata[DATA_W-1:LINK_LSB], {LINK_LSB{1'b0}}};
          W_CTRL:  ctrl  <= wdata;
          default: ;
        endcase
      end else if (clr_en) begin
        ctrl[0] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldf_seq.sv
module ldf_seq
  import ldf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              seg_done,
  input  logic [ADDR_W-1:0] link,
  input  logic              mem_rvalid,
  input  logic              fetched_en,
  output logic              busy,
  output logic              seg_valid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fetch_we,
  output logic [IDX_W-1:0]  fetch_idx,
  output logic              clr_en
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  ldf_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             link_zero;
  logic             last_word;

  assign link_zero = (link == '0);
  assign last_word = (idx == W_CTRL);
  assign fetch_we  = (state == ST_FETCH) && mem_rvalid && !sw_stop;
  assign fetch_idx = idx;
  assign clr_en    = (state == ST_RUN) && seg_done && !sw_stop && link_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      seg_valid <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      idx       <= '0;
    end else begin
      seg_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (sw_start) begin
            state     <= ST_RUN;
            busy      <= 1'b1;
            seg_valid <= 1'b1;
          end
        end
        ST_RUN: begin
          if (sw_stop) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else if (seg_done) begin
            if (link_zero) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
            end else begin
              state    <= ST_FETCH;
              mem_req  <= 1'b1;
              mem_addr <= link;
              idx      <= '0;
            end
          end
        end
        ST_FETCH: begin
          if (sw_stop) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            mem_req <= 1'b0;
          end else if (mem_rvalid) begin
            if (last_word) begin
              mem_req <= 1'b0;
              if (fetched_en) begin
                state     <= ST_RUN;
                seg_valid <= 1'b1;
              end else begin
                state <= ST_IDLE;
                busy  <= 1'b0;
              end
            end else begin
              idx      <= idx + 1'b1;
              mem_addr <= mem_addr + WORD_BYTES;
            end
          end
        end
        default: begin
          state   <= ST_IDLE;
          busy    <= 1'b0;
          mem_req <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
  import ldf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [3:0]        reg_wr_word,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [3:0]        reg_rd_word,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              seg_valid,
  output logic [DATA_W-1:0] seg_src,
  output logic [DATA_W-1:0] seg_dst,
  output logic [LEN_W-1:0]  seg_len,
  output logic [DATA_W-1:0] seg_ctrl,
  input  logic              seg_done,
  output logic              busy
);
  logic              sw_ctrl, sw_start, sw_stop, sw_we;
  logic              fetch_we, clr_en;
  logic [IDX_W-1:0]  fetch_idx;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_idx;
  logic [DATA_W-1:0] rf_data;
  logic [DATA_W-1:0] link;

  assign sw_ctrl  = reg_wr_en && (reg_wr_word == W_CTRL);
  assign sw_start = sw_ctrl && reg_wr_data[0] && !busy;
  assign sw_stop  = sw_ctrl && !reg_wr_data[0] && busy;
  assign sw_we    = reg_wr_en && (!busy || sw_stop);

  assign rf_we   = sw_we || fetch_we;
  assign rf_idx  = sw_we ? reg_wr_word : fetch_idx;
  assign rf_data = sw_we ? reg_wr_data : mem_rdata;

  ldf_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) regs_i (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .widx  (rf_idx),
    .wdata (rf_data),
    .clr_en(clr_en),
    .ridx  (reg_rd_word),
    .rdata (reg_rd_data),
    .src   (seg_src),
    .dst   (seg_dst),
    .xcnt  (seg_len),
    .link  (link),
    .ctrl  (seg_ctrl)
  );

  ldf_seq #(.ADDR_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .sw_start  (sw_start),
    .sw_stop   (sw_stop),
    .seg_done  (seg_done),
    .link      (link),
    .mem_rvalid(mem_rvalid),
    .fetched_en(mem_rdata[0]),
    .busy      (busy),
    .seg_valid (seg_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .fetch_we  (fetch_we),
    .fetch_idx (fetch_idx),
    .clr_en    (clr_en)
  );
endmodule

// File: rtl/desc_chain_engine_chk.sv
module desc_chain_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              seg_valid,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] seg_src,
  input logic [DATA_W-1:0] seg_dst
);
  // R6
  fetch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (!mem_req || $stable(mem_addr)));

  // R6
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |=> (!mem_req || (mem_addr == $past(mem_addr) + 32'd4)));

  // R3
  seg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid |=> !seg_valid);

  // R3
  seg_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> busy);

  // R8
  seg_fetch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !seg_valid);

  // R2
  seg_align_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_src[1:0] == 2'b00 && seg_dst[1:0] == 2'b00));
endmodule

bind desc_chain_engine desc_chain_engine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .seg_valid (seg_valid),
  .mem_req   (mem_req),
  .mem_rvalid(mem_rvalid),
  .mem_addr  (mem_addr),
  .seg_src   (seg_src),
  .seg_dst   (seg_dst)
);

// File: tb/desc_chain_engine_tb_top.sv
`timescale 1ns/1ps
module desc_chain_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [3:0]  reg_wr_word;
  logic [31:0] reg_wr_data;
  logic [3:0]  reg_rd_word;
  logic [31:0] reg_rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        seg_valid;
  logic [31:0] seg_src, seg_dst, seg_ctrl;
  logic [15:0] seg_len;
  logic        seg_done;
  logic        busy;

  always #2 clk = ~clk;

  desc_chain_engine dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_word(reg_wr_word), .reg_wr_data(reg_wr_data),
    .reg_rd_word(reg_rd_word), .reg_rd_data(reg_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .seg_valid(seg_valid), .seg_src(seg_src), .seg_dst(seg_dst), .seg_len(seg_len),
    .seg_ctrl(seg_ctrl), .seg_done(seg_done), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic cmp_on = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // memory with optional pseudo-random stalls
  logic [31:0] mem_m [0:255];
  logic        stall_en = 1'b0;
  logic [7:0]  lfsr = 8'h5A;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rvalid = mem_req && (!stall_en || lfsr[1:0] != 2'b00);
    mem_rdata  = mem_m[mem_addr[9:2]];
  end

  // behavioural reference model
  int          m_mode, m_idx, wi;
  logic        m_busy, m_segv, m_mreq;
  logic [31:0] m_maddr, m_rd, nrd;
  logic [31:0] m_r [0:8];

  function automatic logic [31:0] msk(input int i, input logic [31:0] d);
    if (i == 0 || i == 1) return d & ~32'h3;
    if (i == 2) return d & 32'hFFFF;
    if (i == 7) return d & ~32'h1F;
    return d;
  endfunction

  function automatic logic [31:0] rdv(input int i);
    if (i <= 8 && i != 6) return m_r[i];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_idx = 0; m_busy = 0; m_segv = 0; m_mreq = 0;
      m_maddr = 0; m_rd = 0;
      for (int k = 0; k <= 8; k++) m_r[k] = 0;
    end else begin
      nrd = rdv(int'(reg_rd_word));
      wi = int'(reg_wr_word);
      m_segv = 0;
      if (m_mode == 0) begin
        if (reg_wr_en && wi <= 8 && wi != 6) m_r[wi] = msk(wi, reg_wr_data);
        if (reg_wr_en && wi == 8 && reg_wr_data[0]) begin m_mode = 1; m_segv = 1; end
      end else if (reg_wr_en && wi == 8 && !reg_wr_data[0]) begin
        m_r[8] = reg_wr_data; m_mode = 0; m_mreq = 0;
      end else if (m_mode == 1) begin
        if (seg_done) begin
          if (m_r[7] == 0) begin m_r[8][0] = 1'b0; m_mode = 0; end
          else begin m_mode = 2; m_mreq = 1; m_maddr = m_r[7]; m_idx = 0; end
        end
      end else if (mem_rvalid) begin
        if (m_idx != 6) m_r[m_idx] = msk(m_idx, mem_rdata);
        if (m_idx == 8) begin
          m_mreq = 0;
          if (mem_rdata[0]) begin m_mode = 1; m_segv = 1; end
          else m_mode = 0;
        end else begin
          m_idx++; m_maddr = m_maddr + 4;
        end
      end
      m_busy = (m_mode != 0);
      m_rd = nrd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(busy === m_busy, "R3 busy vs model", {31'b0, busy}, {31'b0, m_busy});
      chk(seg_valid === m_segv, "R3 seg_valid vs model", {31'b0, seg_valid}, {31'b0, m_segv});
      if (m_segv) begin
        chk(seg_src === m_r[0], "R7 seg_src vs model", seg_src, m_r[0]);
        chk(seg_dst === m_r[1], "R7 seg_dst vs model", seg_dst, m_r[1]);
        chk({16'b0, seg_len} === m_r[2], "R7 seg_len vs model", {16'b0, seg_len}, m_r[2]);
        chk(seg_ctrl === m_r[8], "R7 seg_ctrl vs model", seg_ctrl, m_r[8]);
      end
      chk(mem_req === m_mreq, "R6 mem_req vs model", {31'b0, mem_req}, {31'b0, m_mreq});
      if (m_mreq) chk(mem_addr === m_maddr, "R6 mem_addr vs model", mem_addr, m_maddr);
      chk(reg_rd_data === m_rd, "R1 reg_rd_data vs model", reg_rd_data, m_rd);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R3 watchdog expired actual=%0d expected=<50000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_wr_word = w; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] w, input logic [31:0] exp, input string tag);
    reg_rd_word = w;
    @(negedge clk);
    chk(reg_rd_data === exp, tag, reg_rd_data, exp);
  endtask

  task automatic done_pulse();
    seg_done = 1'b1;
    @(negedge clk);
    seg_done = 1'b0;
  endtask

  task automatic wait_segv();
    for (int i = 0; i < 400 && !seg_valid; i++) @(negedge clk);
    chk(seg_valid === 1'b1, "R8 segment launched after fetch", {31'b0, seg_valid}, 32'd1);
  endtask

  task automatic put_desc(input int base, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] x, input logic [31:0] zy, input logic [31:0] ss,
                          input logic [31:0] ds, input logic [31:0] lk, input logic [31:0] c);
    int b;
    b = base / 4;
    mem_m[b]   = s;  mem_m[b+1] = d;  mem_m[b+2] = x;  mem_m[b+3] = zy;
    mem_m[b+4] = ss; mem_m[b+5] = ds; mem_m[b+6] = 32'hDEADBEEF;
    mem_m[b+7] = lk; mem_m[b+8] = c;
    for (int k = 9; k < 16; k++) mem_m[b+k] = 32'hBAD00000 + k;
  endtask

  initial begin
    rst = 1'b1; reg_wr_en = 0; reg_wr_word = 0; reg_wr_data = 0;
    reg_rd_word = 0; seg_done = 0;
    for (int k = 0; k < 256; k++) mem_m[k] = 32'h0;
    put_desc(32'h100, 32'h2000, 32'h3000, 32'h80, 0, 0, 0, 32'h160, 32'h231);
    put_desc(32'h160, 32'h2103, 32'h3104, 32'h0001FFF0, 7, 8, 9, 32'h200, 32'h35);
    put_desc(32'h200, 32'h4000, 32'h5000, 32'h10, 0, 0, 0, 32'h0, 32'hF1);
    put_desc(32'h240, 32'h6000, 32'h7000, 32'h20, 0, 0, 0, 32'h0, 32'h30);
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp_on = 1'b1;
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk(busy === 1'b0, "R12 busy after reset", {31'b0, busy}, 0);
    chk(mem_req === 1'b0, "R12 mem_req after reset", {31'b0, mem_req}, 0);
    chk(seg_valid === 1'b0, "R12 seg_valid after reset", {31'b0, seg_valid}, 0);
    rd_chk(4'd8, 32'h0, "R12 ctrl after reset");
    rd_chk(4'd7, 32'h0, "R12 link after reset");

    // R1 / R2 register window and masks
    wr(4'd0, 32'h12345677); rd_chk(4'd0, 32'h12345674, "R2 src alignment mask");
    wr(4'd1, 32'h0000ABCE); rd_chk(4'd1, 32'h0000ABCC, "R2 dst alignment mask");
    wr(4'd2, 32'h0012FFFF); rd_chk(4'd2, 32'h0000FFFF, "R2 count width mask");
    wr(4'd3, 32'h11);       rd_chk(4'd3, 32'h11, "R1 zy count register");
    wr(4'd4, 32'h22);       rd_chk(4'd4, 32'h22, "R1 src step register");
    wr(4'd5, 32'h33);       rd_chk(4'd5, 32'h33, "R1 dst step register");
    wr(4'd7, 32'h13F);      rd_chk(4'd7, 32'h120, "R2 link alignment mask");
    wr(4'd6, 32'hFFFF);     rd_chk(4'd6, 32'h0, "R1 reserved index reads zero");
    wr(4'd10, 32'h5);       rd_chk(4'd10, 32'h0, "R1 unmapped index reads zero");

    // R11 stray completion while idle
    done_pulse();
    chk(busy === 1'b0, "R11 seg_done idle keeps busy low", {31'b0, busy}, 0);
    rd_chk(4'd8, 32'h0, "R11 seg_done idle leaves ctrl");

    // R3 / R4 / R5 single segment
    wr(4'd7, 32'h0); wr(4'd0, 32'h1000); wr(4'd2, 32'h40);
    wr(4'd8, 32'h00000A01);
    chk(busy === 1'b1, "R3 busy after start", {31'b0, busy}, 1);
    chk(seg_valid === 1'b1, "R3 seg_valid after start", {31'b0, seg_valid}, 1);
    chk(seg_src === 32'h1000, "R3 seg_src", seg_src, 32'h1000);
    chk(seg_len === 16'h40, "R3 seg_len", {16'b0, seg_len}, 32'h40);
    chk(seg_ctrl === 32'hA01, "R3 seg_ctrl", seg_ctrl, 32'hA01);
    @(negedge clk);
    chk(seg_valid === 1'b0, "R3 seg_valid one cycle", {31'b0, seg_valid}, 0);
    wr(4'd0, 32'h5550);
    wr(4'd8, 32'hFFFFFFFF);
    done_pulse();
    chk(busy === 1'b0, "R5 busy low after last segment", {31'b0, busy}, 0);
    chk(mem_req === 1'b0, "R5 no fetch on zero link", {31'b0, mem_req}, 0);
    rd_chk(4'd8, 32'hA00, "R5 enable cleared, R4 ctrl write ignored");
    rd_chk(4'd0, 32'h1000, "R4 src write ignored while busy");

    // R6..R9 three-descriptor chain with stalls
    stall_en = 1'b1;
    wr(4'd0, 32'h800); wr(4'd2, 32'h20); wr(4'd7, 32'h100);
    wr(4'd8, 32'h31);
    chk(seg_valid === 1'b1, "R3 chain first launch", {31'b0, seg_valid}, 1);
    reg_rd_word = 4'd7;
    repeat (2) @(negedge clk);
    done_pulse();
    chk(mem_req === 1'b1, "R6 fetch starts", {31'b0, mem_req}, 1);
    chk(mem_addr === 32'h100, "R6 fetch address is link", mem_addr, 32'h100);
    chk(reg_rd_data === 32'h100, "R9 link shows descriptor in fetch", reg_rd_data, 32'h100);
    done_pulse();
    chk(mem_req === 1'b1, "R11 seg_done during fetch ignored", {31'b0, mem_req}, 1);
    for (int i = 0; i < 200 && !(mem_req && mem_addr == 32'h120); i++) @(negedge clk);
    @(negedge clk);
    chk(reg_rd_data === 32'h160, "R9 live link after link word", reg_rd_data, 32'h160);
    wait_segv();
    chk(seg_src === 32'h2000, "R7 desc1 src", seg_src, 32'h2000);
    chk(seg_len === 16'h80, "R7 desc1 len", {16'b0, seg_len}, 32'h80);
    chk(seg_ctrl === 32'h231, "R7 desc1 ctrl", seg_ctrl, 32'h231);
    chk(mem_req === 1'b0, "R8 request low after ninth word", {31'b0, mem_req}, 0);
    @(negedge clk);
    done_pulse();
    wait_segv();
    chk(seg_src === 32'h2100, "R2 fetched src masked", seg_src, 32'h2100);
    chk(seg_dst === 32'h3104, "R7 desc2 dst", seg_dst, 32'h3104);
    chk(seg_len === 16'hFFF0, "R2 fetched count masked", {16'b0, seg_len}, 32'hFFF0);
    rd_chk(4'd3, 32'h7, "R7 desc2 zy");
    rd_chk(4'd4, 32'h8, "R7 desc2 src step");
    rd_chk(4'd5, 32'h9, "R7 desc2 dst step");
    rd_chk(4'd6, 32'h0, "R7 reserved word discarded");
    rd_chk(4'd7, 32'h200, "R7 desc2 link");
    done_pulse();
    wait_segv();
    chk(seg_src === 32'h4000, "R7 desc3 src", seg_src, 32'h4000);
    @(negedge clk);
    done_pulse();
    chk(busy === 1'b0, "R5 chain ends on zero link", {31'b0, busy}, 0);
    stall_en = 1'b0;

    // R8 fetched descriptor with enable clear
    wr(4'd7, 32'h240);
    wr(4'd8, 32'h1);
    @(negedge clk);
    done_pulse();
    for (int i = 0; i < 200 && mem_req; i++) @(negedge clk);
    chk(busy === 1'b0, "R8 disabled descriptor idles", {31'b0, busy}, 0);
    chk(seg_valid === 1'b0, "R8 disabled descriptor no launch", {31'b0, seg_valid}, 0);
    rd_chk(4'd8, 32'h30, "R8 fetched ctrl loaded");

    // R10 stop during fetch
    wr(4'd7, 32'h100);
    wr(4'd8, 32'h1);
    @(negedge clk);
    done_pulse();
    repeat (2) @(negedge clk);
    wr(4'd8, 32'h700);
    chk(busy === 1'b0, "R10 stop in fetch busy", {31'b0, busy}, 0);
    chk(mem_req === 1'b0, "R10 stop in fetch request", {31'b0, mem_req}, 0);
    rd_chk(4'd8, 32'h700, "R10 stop value stored");

    // R10 stop during active segment
    wr(4'd8, 32'h1);
    @(negedge clk);
    wr(4'd8, 32'h0);
    chk(busy === 1'b0, "R10 stop in run busy", {31'b0, busy}, 0);
    chk(seg_valid === 1'b0, "R10 stop in run no launch", {31'b0, seg_valid}, 0);
    done_pulse();
    chk(mem_req === 1'b0, "R10 completion after stop ignored", {31'b0, mem_req}, 0);
    chk(busy === 1'b0, "R11 completion after stop keeps idle", {31'b0, busy}, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule